// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block behaves like a small serial EEPROM that is reached over a three-wire bus with a chip select. The bus master selects it with `sel_i`, clocks bits in on `sdi_i` on each rising edge of `sck_i`, and reads bits back on `sdo_o`. Every frame begins with a start bit, then a two-bit opcode, then an address. The block then reads, writes or erases locations of an internal register array. It can also switch its write protection on and off. `wide_i` sets the width of the array: 16-bit words or 8-bit bytes. The address and data fields change width to match.

A read keeps streaming while the select stays high. Each location is followed by the next one, and the address wraps from the top of the array back to zero. Writes and erases run as a self-timed program cycle of `PROG_CYCLES` system clocks. The serial clock may stop during that time. To poll the cycle, the master drops the select and raises it again. The data line is then low while the cycle is busy and high once it is ready.

The serial pins are sampled on the system clock `clk`. A rising edge of `sck_i` is detected as a change from low to high between two samples.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset every cell reads as all ones and write protection is on. `sdo_en_o` is low whenever `sel_i` is low.
- R2: A frame starts when a 1 is sampled on a rising `sck_i` edge while `sel_i` is high. Zeros before the start bit are ignored. The start bit is followed by a two-bit opcode: READ=10, WRITE=01, ERASE=11. Opcode 00 uses the two most significant address bits to pick the operation: WEN=11, WDS=00, ERAL=10, WRAL=01. Lowering `sel_i` aborts a frame that is not complete.
- R3: With `wide_i`=1 the address is AW bits and the data is 16 bits. With `wide_i`=0 the address is AW+1 bits and the data is 8 bits. Word w occupies byte 2w (low half) and byte 2w+1 (high half).
- R4: On a READ, the rising edge that carries the last address bit drives a dummy 0 onto `sdo_o`. Each later rising edge drives the next data bit, most significant bit first.
- R5: While `sel_i` stays high, a read moves on to the next location. After the highest location it wraps to location 0.
- R6: WRITE programs the addressed location with the data that was shifted in, and it needs no erase beforehand.
- R7: ERASE sets one location to all ones. ERAL sets every location to all ones.
- R8: WRAL programs every location with the same data.
- R9: WRITE, ERASE, ERAL and WRAL are ignored until WEN completes. They are ignored again after WDS.
- R10: Every program cycle lasts PROG_CYCLES clocks. When `sel_i` is raised again after a program cycle has started, `sdo_o` is 0 while the cycle runs and 1 once it has finished.
- R11: Start bits are ignored while a program cycle runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| wide_i | input | 1 | 1: 16-bit words, 0: 8-bit bytes |
| sdo_o | output | 1 | Serial data out / ready-busy |
| sdo_en_o | output | 1 | Output enable for `sdo_o` |

## Verification
The bench targets the wrap of a streaming read at the top address. A design that got this wrong would run off the array or stay stuck on the last location. It checks the mapping of words onto byte pairs, where swapped halves show up as byte-swapped reads. It issues writes before WEN, after WDS and during a running program cycle, and a faulty protection latch or busy gate would let those writes change the array. It also aborts a WEN frame part-way. A decoder that acts before the last address bit would then leave the array writable.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_OPC, ST_ADR, ST_DAT, ST_RD, ST_HOLD
   } mw_state_e;

   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] EX_WDS  = 2'b00;
   localparam logic [1:0] EX_WRAL = 2'b01;
   localparam logic [1:0] EX_ERAL = 2'b10;
   localparam logic [1:0] EX_WEN  = 2'b11;
endpackage

// File: rtl/mw_sck_edge.sv
module mw_sck_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   output logic rise_o
);
   logic sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_i;
   end

   assign rise_o = sck_i & ~sck_q;
endmodule

// File: rtl/mw_busy_timer.sv
module mw_busy_timer #(
   parameter int CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(CYCLES + 1);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (start_i)      cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mw_array.sv
module mw_array #(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wide_i,
   input  logic          wr_en_i,
   input  logic          wr_all_i,
   input  logic [AW:0]   wr_addr_i,
   input  logic [15:0]   wr_data_i,
   input  logic [AW:0]   rd_addr_i,
   output logic [15:0]   rd_data_o
);
   localparam int BAW = AW + 1;
   localparam int NB  = 2 ** BAW;

   logic [NB*8-1:0] flat;

   for (genvar i = 0; i < NB; i++) begin : g_cell
      localparam logic [BAW-1:0] IDX = BAW'(i);
      logic [7:0] cell_q;
      logic       hit;
      assign hit = wr_all_i |
                   (wide_i ? (wr_addr_i[AW-1:0] == IDX[BAW-1:1]) : (wr_addr_i == IDX));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cell_q <= 8'hFF;
         else if (wr_en_i && hit) cell_q <= (wide_i && IDX[0]) ? wr_data_i[15:8] : wr_data_i[7:0];
      end
      assign flat[i*8 +: 8] = cell_q;
   end

   logic [BAW-1:0] lo_idx, hi_idx;
   assign lo_idx = {rd_addr_i[AW-1:0], 1'b0};
   assign hi_idx = {rd_addr_i[AW-1:0], 1'b1};

   assign rd_data_o = wide_i ? {flat[int'(hi_idx)*8 +: 8], flat[int'(lo_idx)*8 +: 8]}
                             : {8'h00, flat[int'(rd_addr_i)*8 +: 8]};
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
   import mw_eeprom_pkg::*;
#(
   parameter int AW          = 6,
   parameter int PROG_CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic sck_i,
   input  logic sdi_i,
   input  logic wide_i,
   output logic sdo_o,
   output logic sdo_en_o
);
   localparam int BAW = AW + 1;

   if (AW < 3 || AW > 10) begin : g_bad_aw
      $error("AW out of range 3..10");
   end
   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("PROG_CYCLES must be at least 1");
   end

   mw_state_e      st_q;
   logic [4:0]     cnt_q, rd_cnt_q, adr_len, dat_len;
   logic [1:0]     opc_q, top2;
   logic [BAW-1:0] adr_q, adr_nx, msk, rd_adr_q, rd_next, wr_adr_q;
   logic [14:0]    dat_q;
   logic [15:0]    shr_q, wr_dat_q, rd_word;
   logic           q_q, wen_q, poll_q, wr_req_q, wr_all_q, busy, rise;

   mw_sck_edge u_edge (.clk(clk), .rst_n(rst_n), .sck_i(sck_i), .rise_o(rise));

   mw_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(wr_req_q), .busy_o(busy));

   mw_array #(.AW(AW)) u_array (
      .clk(clk), .rst_n(rst_n), .wide_i(wide_i),
      .wr_en_i(wr_req_q), .wr_all_i(wr_all_q), .wr_addr_i(wr_adr_q),
      .wr_data_i(wr_dat_q), .rd_addr_i(rd_adr_q), .rd_data_o(rd_word));

   assign adr_len = wide_i ? 5'(AW) : 5'(BAW);
   assign dat_len = wide_i ? 5'd16 : 5'd8;
   assign msk     = wide_i ? {1'b0, {AW{1'b1}}} : {BAW{1'b1}};
   assign adr_nx  = {adr_q[BAW-2:0], sdi_i};
   assign top2    = wide_i ? adr_nx[AW-1 -: 2] : adr_nx[BAW-1 -: 2];
   assign rd_next = (rd_adr_q + 1'b1) & msk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cnt_q    <= '0;
         rd_cnt_q <= '0;
         opc_q    <= '0;
         adr_q    <= '0;
         dat_q    <= '0;
         rd_adr_q <= '0;
         shr_q    <= '0;
         q_q      <= 1'b0;
         wen_q    <= 1'b0;
         poll_q   <= 1'b0;
         wr_req_q <= 1'b0;
         wr_all_q <= 1'b0;
         wr_adr_q <= '0;
         wr_dat_q <= '0;
      end else begin
         wr_req_q <= 1'b0;
         if (!sel_i) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
         end else if (rise) begin
            unique case (st_q)
               ST_IDLE: if (sdi_i && !busy) begin
                  st_q   <= ST_OPC;
                  cnt_q  <= '0;
                  poll_q <= 1'b0;
                  opc_q  <= '0;
                  adr_q  <= '0;
                  dat_q  <= '0;
               end
               ST_OPC: begin
                  opc_q <= {opc_q[0], sdi_i};
                  if (cnt_q == 5'd1) begin
                     st_q  <= ST_ADR;
                     cnt_q <= '0;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               ST_ADR: begin
                  adr_q <= adr_nx;
                  if (cnt_q == adr_len - 1'b1) begin
                     cnt_q <= '0;
                     st_q  <= ST_HOLD;
                     unique case (opc_q)
                        OP_READ: begin
                           rd_adr_q <= adr_nx & msk;
                           rd_cnt_q <= '0;
                           q_q      <= 1'b0;
                           st_q     <= ST_RD;
                        end
                        OP_WRITE: st_q <= ST_DAT;
                        OP_ERASE: begin
                           wr_req_q <= wen_q;
                           poll_q   <= wen_q;
                           wr_all_q <= 1'b0;
                           wr_adr_q <= adr_nx & msk;
                           wr_dat_q <= 16'hFFFF;
                        end
                        default: unique case (top2)
                           EX_WEN:  wen_q <= 1'b1;
                           EX_WDS:  wen_q <= 1'b0;
                           EX_ERAL: begin
                              wr_req_q <= wen_q;
                              poll_q   <= wen_q;
                              wr_all_q <= 1'b1;
                              wr_dat_q <= 16'hFFFF;
                           end
                           default: st_q <= ST_DAT;
                        endcase
                     endcase
                  end else cnt_q <= cnt_q + 1'b1;
               end
               ST_DAT: begin
                  dat_q <= {dat_q[13:0], sdi_i};
                  if (cnt_q == dat_len - 1'b1) begin
                     wr_req_q <= wen_q;
                     poll_q   <= wen_q;
                     wr_all_q <= (opc_q == OP_EXT);
                     wr_adr_q <= adr_q & msk;
                     wr_dat_q <= {dat_q, sdi_i};
                     st_q     <= ST_HOLD;
                     cnt_q    <= '0;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               ST_RD: begin
                  if (rd_cnt_q == '0) begin
                     q_q      <= wide_i ? rd_word[15] : rd_word[7];
                     shr_q    <= rd_word;
                     rd_cnt_q <= dat_len - 1'b1;
                     rd_adr_q <= rd_next;
                  end else begin
                     q_q      <= wide_i ? shr_q[14] : shr_q[6];
                     shr_q    <= shr_q << 1;
                     rd_cnt_q <= rd_cnt_q - 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sdo_en_o = sel_i;
   assign sdo_o    = (st_q == ST_RD) ? q_q : (poll_q ? ~busy : 1'b1);
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
   import mw_eeprom_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      sel_i,
   input mw_state_e st,
   input logic      busy,
   input logic      wr_req,
   input logic      wen
);
   AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> st == ST_IDLE); // R2
   AST_WR_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> wen); // R9
   AST_BUSY_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> busy); // R10
   AST_NO_PROG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !wr_req); // R11
endmodule

bind mw_eeprom_slave mw_eeprom_chk chk_i (
   .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .st(st_q),
   .busy(busy), .wr_req(wr_req_q), .wen(wen_q));

// File: tb/mw_eeprom_slave_tb_top.sv
module mw_eeprom_slave_tb_top;
   localparam int PROG = 200;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sel = 1'b0, sck = 1'b0, sdi = 1'b0, wide = 1'b1;
   logic sdo, sdo_en, lastq;
   int   vecs = 0, errs = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   mw_eeprom_slave #(.AW(6), .PROG_CYCLES(PROG)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .sck_i(sck), .sdi_i(sdi),
      .wide_i(wide), .sdo_o(sdo), .sdo_en_o(sdo_en));

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int awid(input logic w); return w ? 6 : 7; endfunction
   function automatic int dwid(input logic w); return w ? 16 : 8; endfunction

   task automatic pulse(input logic b, output logic q);
      @(negedge clk) sdi = b;
      @(negedge clk) sck = 1'b1;
      repeat (2) @(negedge clk);
      q = sdo;
      sck = 1'b0;
      @(negedge clk);
   endtask

   task automatic send(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) pulse(v[i], lastq);
   endtask

   task automatic recv(input int n, output logic [15:0] v);
      logic b;
      v = '0;
      for (int i = 0; i < n; i++) begin
         pulse(1'b0, b);
         v = {v[14:0], b};
      end
   endtask

   task automatic begin_frame(input logic w);
      wide = w;
      @(negedge clk) sel = 1'b1;
      @(negedge clk);
   endtask

   task automatic end_frame;
      @(negedge clk) sel = 1'b0;
      sdi = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_ready; repeat (PROG + 10) @(negedge clk); endtask

   task automatic cmd(input logic w, input logic [1:0] op, input int a);
      begin_frame(w);
      send(1, 1);
      send(32'(op), 2);
      send(32'(a), awid(w));
   endtask

   task automatic ext(input logic w, input logic [1:0] code);
      cmd(w, 2'b00, int'(code) << (awid(w) - 2));
   endtask

   task automatic wr(input logic w, input int a, input logic [15:0] d);
      cmd(w, 2'b01, a);
      send(32'(d), dwid(w));
      end_frame();
      wait_ready();
   endtask

   task automatic rd_check(input string tag, input logic w, input int a, input logic [15:0] exp);
      logic [15:0] v;
      cmd(w, 2'b10, a);
      chk({tag, " R4 dummy"}, 16'(lastq), 16'h0);
      recv(dwid(w), v);
      chk(tag, v, exp);
      end_frame();
   endtask

   task automatic t_reset;
      chk("R1 sdo_en low when deselected", 16'(sdo_en), 16'h0);
      rd_check("R1 erased word 0", 1'b1, 0, 16'hFFFF);
      rd_check("R1 erased byte 127", 1'b0, 127, 16'h00FF);
   endtask

   task automatic t_protect;
      wr(1'b1, 3, 16'h1234);
      rd_check("R9 write before WEN ignored", 1'b1, 3, 16'hFFFF);
   endtask

   task automatic t_write_poll;
      ext(1'b1, 2'b11); end_frame();
      cmd(1'b1, 2'b01, 3);
      send(32'h1234, 16);
      end_frame();
      @(negedge clk) sel = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 busy shows 0", 16'(sdo), 16'h0);
      chk("R1 sdo_en high when selected", 16'(sdo_en), 16'h1);
      wait_ready();
      chk("R10 ready shows 1", 16'(sdo), 16'h1);
      end_frame();
      rd_check("R6 word write", 1'b1, 3, 16'h1234);
      wr(1'b1, 3, 16'hC3A5);
      rd_check("R6 overwrite without erase", 1'b1, 3, 16'hC3A5);
      rd_check("R3 low byte at even address", 1'b0, 6, 16'h00A5);
      rd_check("R3 high byte at odd address", 1'b0, 7, 16'h00C3);
   endtask

   task automatic t_wrap;
      logic [15:0] v;
      wr(1'b0, 127, 16'h00A5);
      wr(1'b0, 0, 16'h005A);
      cmd(1'b0, 2'b10, 127);
      recv(8, v); chk("R5 byte top", v, 16'h00A5);
      recv(8, v); chk("R5 byte wrap to 0", v, 16'h005A);
      end_frame();
      wr(1'b1, 63, 16'h1111);
      cmd(1'b1, 2'b10, 62);
      recv(16, v); chk("R5 word 62", v, 16'hFFFF);
      recv(16, v); chk("R5 word 63", v, 16'h1111);
      recv(16, v); chk("R5 word wrap to 0", v, 16'hFF5A);
      end_frame();
   endtask

   task automatic t_erase;
      cmd(1'b1, 2'b11, 3); end_frame(); wait_ready();
      rd_check("R7 erase one word", 1'b1, 3, 16'hFFFF);
   endtask

   task automatic t_busy_ignore;
      cmd(1'b1, 2'b01, 10); send(32'hAAAA, 16); end_frame();
      cmd(1'b1, 2'b01, 11); send(32'h5555, 16); end_frame();
      wait_ready();
      rd_check("R6 first write kept", 1'b1, 10, 16'hAAAA);
      rd_check("R11 write during busy ignored", 1'b1, 11, 16'hFFFF);
   endtask

   task automatic t_all;
      ext(1'b1, 2'b01); send(32'hBEEF, 16); end_frame(); wait_ready();
      rd_check("R8 WRAL word 0", 1'b1, 0, 16'hBEEF);
      rd_check("R8 WRAL word 40", 1'b1, 40, 16'hBEEF);
      ext(1'b0, 2'b01); send(32'h77, 8); end_frame(); wait_ready();
      rd_check("R8 WRAL byte 5", 1'b0, 5, 16'h0077);
      rd_check("R8 WRAL byte 100", 1'b0, 100, 16'h0077);
      ext(1'b1, 2'b10); end_frame(); wait_ready();
      rd_check("R7 ERAL word 20", 1'b1, 20, 16'hFFFF);
      rd_check("R7 ERAL word 63", 1'b1, 63, 16'hFFFF);
   endtask

   task automatic t_wds_abort;
      logic [15:0] v;
      ext(1'b1, 2'b00); end_frame();
      wr(1'b1, 5, 16'h0000);
      rd_check("R9 write after WDS ignored", 1'b1, 5, 16'hFFFF);
      begin_frame(1'b1);
      send(1, 1); send(0, 2); send(3, 2);
      end_frame();
      wr(1'b1, 6, 16'h0000);
      rd_check("R2 aborted WEN leaves protection", 1'b1, 6, 16'hFFFF);
      ext(1'b1, 2'b11); end_frame();
      wr(1'b1, 6, 16'h6006);
      begin_frame(1'b1);
      send(0, 3); send(1, 1); send(2, 2); send(6, 6);
      chk("R2 leading zeros dummy", 16'(lastq), 16'h0);
      recv(16, v);
      chk("R2 leading zeros then READ", v, 16'h6006);
      end_frame();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_protect();
      t_write_poll();
      t_wrap();
      t_erase();
      t_busy_ignore();
      t_all();
      t_wds_abort();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule